// File: doc/BRIEF.md
# Partition Power-Gate Controller

This block switches up to 32 power partitions on and off and releases the isolation clamps that keep a freshly powered partition cut off from its neighbours. Software drives it through a small 32-bit register bus with four registers: a toggle command, a power status, a clamp-removal command and a clamp status. Each partition's power switch and clamp are modelled by timers, so the effects appear a fixed number of cycles after the command.

Power is changed by toggling rather than by separate set and clear commands. A write to the toggle register with the start bit set selects one partition and inverts its power state once the switch delay has elapsed. While the toggle is in flight, the start bit reads back as busy. Clamp removal takes a one-hot request. Each request bit stays visible until the clamp drops. For one designated pair of partitions, the request bit positions are crossed over. When a partition powers down, its clamp closes again automatically.

Top module: `pgate_ctrl`

## Requirements
- R1: After reset, every partition is off and clamped. The toggle register reads 0 and the clamp-command register reads 0.
- R2: A write to offset 0x030 with bit 8 set and a partition index in bits 4:0 inverts that partition's power bit. The change appears on the TOGGLE_CYCLES-th rising edge after the write edge (default 16).
- R3: A read of the toggle register returns the busy flag in bit 8 and the last accepted index in bits 4:0. Busy is 1 from the edge after the write until the edge on which the power bit flips, and it clears on that same edge.
- R4: A toggle write is ignored when bit 8 is 0 or when a toggle is already busy. The busy flag, the stored index and the power state are then unchanged.
- R5: The power status register at offset 0x038 holds bit n = 1 when partition n is powered.
- R6: A write to offset 0x034 latches its set bits as pending removal commands, which read back as 1. CLAMP_CYCLES edges after the write edge (default 4), the pending bits and the matching clamp-status bits clear together on one edge.
- R7: The clamp status register at offset 0x02C holds bit n = 1 when partition n is clamped.
- R8: A removal request whose target partition is unpowered is dropped. Its command bit does not latch and the clamp stays set.
- R9: Command bits SWAP_A (default 5) and SWAP_B (default 7) are crossed over. Each one acts on the other partition's clamp and is checked against that partition's power. All other bits act on their own partition.
- R10: On the edge where a partition powers off, its clamp bit sets again. An unpowered partition is never unclamped.
- R11: A clamp-command write that arrives while any removal is pending is ignored.
- R12: Writes to the status registers at 0x038 and 0x02C change nothing. reqReady is always 1. Read data appears with rdValid on the edge after the read request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Bus request valid |
| reqReady | output | 1 | Bus request accepted (always 1) |
| reqWrite | input | 1 | 1 = write, 0 = read |
| reqAddr | input | ADDR_W | Byte offset of the register |
| reqWdata | input | 32 | Write data |
| rdValid | output | 1 | Read data valid, one cycle after a read request |
| rdData | output | 32 | Read data |

## Verification
The bench places its reads on the exact edges around each completion: the last cycle in which the toggle is still busy and the power bit has not yet flipped, and the last cycle in which the clamp is still set. A timer that is off by one therefore shows a wrong value. It sends a second toggle while the first is still busy, and a second clamp command while a removal is still pending. A design that accepted either of these would flip another partition or unclamp an extra one. It requests clamp removal for an unpowered partition, and for both members of the crossed pair. A design that ignored the power check, or that did not cross the bits over, would clear the wrong clamp bit. It also powers a partition down after its clamp has been released. A design that failed to close the clamp again would leave a clamp-status bit clear on an unpowered partition.

// File: rtl/pgate_pkg.sv
package pgate_pkg;

  localparam int DATA_W = 32;
  localparam int IDX_W = 5;
  localparam int START_BIT = 8;

  localparam logic [11:0] OFS_CLAMP_STAT = 12'h02C;
  localparam logic [11:0] OFS_TOGGLE     = 12'h030;
  localparam logic [11:0] OFS_CLAMP_CMD  = 12'h034;
  localparam logic [11:0] OFS_PWR_STAT   = 12'h038;

  typedef enum logic [2:0] {
    RD_NONE,
    RD_TOGGLE,
    RD_PWR,
    RD_CLAMP,
    RD_CMD
  } rdSel_e;

  typedef struct packed {
    logic              togBusy;
    logic [IDX_W-1:0]  togIdx;
    logic              togDone;
    logic              cmdLoad;
    logic [DATA_W-1:0] cmdData;
    logic              cmdDone;
    logic              rdEn;
    rdSel_e            rdSel;
  } strobe_t;

  function automatic int crossIdx(input int i, input int a, input int b, input int n);
    int t;
    if (i == a) t = b;
    else if (i == b) t = a;
    else t = i;
    if (t >= n) t = i;
    return t;
  endfunction

endpackage

// File: rtl/pgate_ctrl_seq.sv
module pgate_ctrl_seq
  import pgate_pkg::*;
#(
  parameter int NUM_PART      = 32,
  parameter int TOGGLE_CYCLES = 16,
  parameter int CLAMP_CYCLES  = 4,
  parameter int ADDR_W        = 12
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  input  logic              reqWrite,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [DATA_W-1:0] reqWdata,
  input  logic              cmdPendAny,
  output strobe_t           strb
);

  localparam int TCW = $clog2(TOGGLE_CYCLES + 1);
  localparam int CCW = $clog2(CLAMP_CYCLES + 1);
  localparam logic [TCW-1:0] TOG_LAST = TCW'(TOGGLE_CYCLES - 1);
  localparam logic [CCW-1:0] CLAMP_LAST = CCW'(CLAMP_CYCLES - 1);

  logic             togBusy;
  logic [IDX_W-1:0] togIdx;
  logic [TCW-1:0]   togCnt;
  logic [CCW-1:0]   clampCnt;

  logic isToggle, isCmd, isPwr, isClamp;
  logic wrReq, idxOk, togAccept, togDone, cmdDone;
  rdSel_e rdSel;

  assign isToggle = (reqAddr == ADDR_W'(OFS_TOGGLE));
  assign isCmd    = (reqAddr == ADDR_W'(OFS_CLAMP_CMD));
  assign isPwr    = (reqAddr == ADDR_W'(OFS_PWR_STAT));
  assign isClamp  = (reqAddr == ADDR_W'(OFS_CLAMP_STAT));

  assign wrReq     = reqValid && reqWrite;
  assign idxOk     = (int'(reqWdata[IDX_W-1:0]) < NUM_PART);
  assign togAccept = wrReq && isToggle && reqWdata[START_BIT] && !togBusy && idxOk;
  assign togDone   = togBusy && (togCnt == TOG_LAST);
  assign cmdDone   = cmdPendAny && (clampCnt == CLAMP_LAST);

  // toggle timer
  always_ff @(posedge clk) begin
    if (!rstN) begin
      togBusy <= 1'b0;
      togIdx  <= '0;
      togCnt  <= '0;
    end else if (togAccept) begin
      togBusy <= 1'b1;
      togIdx  <= reqWdata[IDX_W-1:0];
      togCnt  <= '0;
    end else if (togBusy) begin
      if (togDone) begin
        togBusy <= 1'b0;
        togCnt  <= '0;
      end else begin
        togCnt <= togCnt + 1'b1;
      end
    end
  end

  // clamp-removal timer, runs while any command is pending
  always_ff @(posedge clk) begin
    if (!rstN) begin
      clampCnt <= '0;
    end else if (!cmdPendAny || cmdDone) begin
      clampCnt <= '0;
    end else begin
      clampCnt <= clampCnt + 1'b1;
    end
  end

  always_comb begin
    rdSel = RD_NONE;
    if (isToggle)     rdSel = RD_TOGGLE;
    else if (isPwr)   rdSel = RD_PWR;
    else if (isClamp) rdSel = RD_CLAMP;
    else if (isCmd)   rdSel = RD_CMD;
  end

  always_comb begin
    strb.togBusy = togBusy;
    strb.togIdx  = togIdx;
    strb.togDone = togDone;
    strb.cmdLoad = wrReq && isCmd && !cmdPendAny;
    strb.cmdData = reqWdata;
    strb.cmdDone = cmdDone;
    strb.rdEn    = reqValid && !reqWrite;
    strb.rdSel   = rdSel;
  end

endmodule

// File: rtl/pgate_state.sv
module pgate_state
  import pgate_pkg::*;
#(
  parameter int NUM_PART = 32,
  parameter int SWAP_A   = 5,
  parameter int SWAP_B   = 7
) (
  input  logic                clk,
  input  logic                rstN,
  input  strobe_t             strb,
  output logic [NUM_PART-1:0] powerVec,
  output logic [NUM_PART-1:0] clampVec,
  output logic [NUM_PART-1:0] cmdPend,
  output logic                rdValid,
  output logic [DATA_W-1:0]   rdData
);

  logic [NUM_PART-1:0] tgtPwr;
  logic [NUM_PART-1:0] relMask;
  logic [NUM_PART-1:0] togMask;
  logic [NUM_PART-1:0] offMask;
  logic [NUM_PART-1:0] clampClr;
  logic [DATA_W-1:0]   rdNext;

  // crossed mapping between command bits and partitions (an involution)
  for (genvar i = 0; i < NUM_PART; i++) begin : g_map
    localparam int T = crossIdx(i, SWAP_A, SWAP_B, NUM_PART);
    assign tgtPwr[i]  = powerVec[T];
    assign relMask[i] = cmdPend[T];
  end

  assign togMask  = strb.togDone ? (NUM_PART'(1) << strb.togIdx) : '0;
  assign offMask  = togMask & powerVec;
  assign clampClr = strb.cmdDone ? (relMask & powerVec) : '0;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      powerVec <= '0;
      clampVec <= '1;
      cmdPend  <= '0;
    end else begin
      powerVec <= powerVec ^ togMask;
      clampVec <= (clampVec & ~clampClr) | offMask;
      if (strb.cmdDone) cmdPend <= '0;
      else if (strb.cmdLoad) cmdPend <= strb.cmdData[NUM_PART-1:0] & tgtPwr;
    end
  end

  always_comb begin
    unique case (strb.rdSel)
      RD_TOGGLE: rdNext = DATA_W'({strb.togBusy, 3'b000, strb.togIdx});
      RD_PWR:    rdNext = DATA_W'(powerVec);
      RD_CLAMP:  rdNext = DATA_W'(clampVec);
      RD_CMD:    rdNext = DATA_W'(cmdPend);
      default:   rdNext = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rdValid <= 1'b0;
      rdData  <= '0;
    end else begin
      rdValid <= strb.rdEn;
      if (strb.rdEn) rdData <= rdNext;
    end
  end

endmodule

// File: rtl/pgate_ctrl.sv
module pgate_ctrl
  import pgate_pkg::*;
#(
  parameter int NUM_PART      = 32,
  parameter int TOGGLE_CYCLES = 16,
  parameter int CLAMP_CYCLES  = 4,
  parameter int SWAP_A        = 5,
  parameter int SWAP_B        = 7,
  parameter int ADDR_W        = 12
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  output logic              reqReady,
  input  logic              reqWrite,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [31:0]       reqWdata,
  output logic              rdValid,
  output logic [31:0]       rdData
);

  strobe_t             strb;
  logic [NUM_PART-1:0] powerVec;
  logic [NUM_PART-1:0] clampVec;
  logic [NUM_PART-1:0] cmdPend;
  logic                togBusy;

  assign reqReady = 1'b1;
  assign togBusy  = strb.togBusy;

  pgate_ctrl_seq #(
    .NUM_PART(NUM_PART),
    .TOGGLE_CYCLES(TOGGLE_CYCLES),
    .CLAMP_CYCLES(CLAMP_CYCLES),
    .ADDR_W(ADDR_W)
  ) u_seq (
    .clk(clk),
    .rstN(rstN),
    .reqValid(reqValid),
    .reqWrite(reqWrite),
    .reqAddr(reqAddr),
    .reqWdata(reqWdata),
    .cmdPendAny(|cmdPend),
    .strb(strb)
  );

  pgate_state #(
    .NUM_PART(NUM_PART),
    .SWAP_A(SWAP_A),
    .SWAP_B(SWAP_B)
  ) u_state (
    .clk(clk),
    .rstN(rstN),
    .strb(strb),
    .powerVec(powerVec),
    .clampVec(clampVec),
    .cmdPend(cmdPend),
    .rdValid(rdValid),
    .rdData(rdData)
  );

endmodule

// File: rtl/pgate_ctrl_chk.sv
module pgate_ctrl_chk
  import pgate_pkg::*;
#(
  parameter int NUM_PART = 32,
  parameter int ADDR_W   = 12
) (
  input logic                clk,
  input logic                rstN,
  input logic                reqValid,
  input logic                reqWrite,
  input logic [ADDR_W-1:0]   reqAddr,
  input logic                rdValid,
  input logic [NUM_PART-1:0] powerVec,
  input logic [NUM_PART-1:0] clampVec,
  input logic [NUM_PART-1:0] cmdPend,
  input logic                togBusy
);

  // R10
  off_clamped_chk: assert property (@(posedge clk) disable iff (!rstN)
    ((~powerVec & ~clampVec) == '0));

  // R2
  one_flip_chk: assert property (@(posedge clk) disable iff (!rstN)
    $countones(powerVec ^ $past(powerVec)) <= 1);

  // R3
  flip_after_busy_chk: assert property (@(posedge clk) disable iff (!rstN)
    (powerVec != $past(powerVec)) |-> $past(togBusy));

  // R12
  read_latency_chk: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && !reqWrite) |=> rdValid);

  // R6
  pend_from_write_chk: assert property (@(posedge clk) disable iff (!rstN)
    ((cmdPend != '0) && ($past(cmdPend) == '0)) |->
      $past(reqValid && reqWrite && (reqAddr == ADDR_W'(OFS_CLAMP_CMD))));

  // R6
  release_needs_cmd_chk: assert property (@(posedge clk) disable iff (!rstN)
    (($past(clampVec) & ~clampVec) != '0) |-> ($past(cmdPend) != '0));

endmodule

bind pgate_ctrl pgate_ctrl_chk #(
  .NUM_PART(NUM_PART),
  .ADDR_W(ADDR_W)
) u_chk (
  .clk(clk),
  .rstN(rstN),
  .reqValid(reqValid),
  .reqWrite(reqWrite),
  .reqAddr(reqAddr),
  .rdValid(rdValid),
  .powerVec(powerVec),
  .clampVec(clampVec),
  .cmdPend(cmdPend),
  .togBusy(togBusy)
);

// File: tb/tb_pgate_ctrl.sv
module tb_pgate_ctrl;

  localparam logic [11:0] A_CST = 12'h02C;
  localparam logic [11:0] A_TOG = 12'h030;
  localparam logic [11:0] A_CMD = 12'h034;
  localparam logic [11:0] A_PWR = 12'h038;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        reqValid = 1'b0;
  logic        reqWrite = 1'b0;
  logic [11:0] reqAddr = '0;
  logic [31:0] reqWdata = '0;
  logic        reqReady;
  logic        rdValid;
  logic [31:0] rdData;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  typedef struct {
    logic [31:0] val;
    string       tag;
  } exp_t;

  exp_t expQ[$];

  always #5 clk = ~clk;

  pgate_ctrl dut (
    .clk(clk),
    .rstN(rstN),
    .reqValid(reqValid),
    .reqReady(reqReady),
    .reqWrite(reqWrite),
    .reqAddr(reqAddr),
    .reqWdata(reqWdata),
    .rdValid(rdValid),
    .rdData(rdData)
  );

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    reqValid = 1'b1;
    reqWrite = 1'b1;
    reqAddr  = a;
    reqWdata = d;
    @(negedge clk);
    reqValid = 1'b0;
    reqWrite = 1'b0;
  endtask

  task automatic rd(input logic [11:0] a, input logic [31:0] e, input string tag);
    expQ.push_back('{val: e, tag: tag});
    reqValid = 1'b1;
    reqWrite = 1'b0;
    reqAddr  = a;
    @(negedge clk);
    reqValid = 1'b0;
  endtask

  // monitor / scoreboard
  always @(negedge clk) begin
    if (rstN && rdValid) begin
      checks++;
      if (expQ.size() == 0) begin
        fails++;
        $display("FAIL R12: unexpected read data actual %h expected none", rdData);
      end else begin
        exp_t e;
        e = expQ.pop_front();
        if (rdData !== e.val) begin
          fails++;
          $display("FAIL %s: actual %h expected %h", e.tag, rdData, e.val);
        end
      end
    end
  end

  task automatic summary();
    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog: actual hung expected completion");
    summary();
  end

  initial begin
    idle(4);
    rstN = 1'b1;
    idle(1);

    // R1 reset state, R7 clamp status, R12 ready
    checks++;
    if (reqReady !== 1'b1) begin
      fails++;
      $display("FAIL R12: reqReady actual %b expected 1", reqReady);
    end
    rd(A_TOG, 32'h0, "R1 toggle");
    rd(A_PWR, 32'h0, "R1 power");
    rd(A_CST, 32'hFFFF_FFFF, "R1 R7 clamp");
    rd(A_CMD, 32'h0, "R1 cmd");

    // R2 R3 R5 toggle partition 3, read around completion
    wr(A_TOG, 32'h103);
    rd(A_TOG, 32'h103, "R3 busy");
    idle(14);
    rd(A_PWR, 32'h0, "R2 before flip");
    rd(A_PWR, 32'h8, "R2 R5 after flip");
    rd(A_TOG, 32'h003, "R3 busy cleared");

    // R4 toggle while busy is ignored
    wr(A_TOG, 32'h106);
    wr(A_TOG, 32'h107);
    rd(A_TOG, 32'h106, "R4 busy write");
    idle(16);
    rd(A_PWR, 32'h48, "R4 busy write power");
    rd(A_TOG, 32'h006, "R3 index kept");

    // R4 start bit clear is ignored
    wr(A_TOG, 32'h009);
    idle(20);
    rd(A_TOG, 32'h006, "R4 no start");
    rd(A_PWR, 32'h48, "R4 no start power");

    // R6 clamp removal on powered partition 3
    wr(A_CMD, 32'h8);
    rd(A_CMD, 32'h8, "R6 pending");
    idle(2);
    rd(A_CST, 32'hFFFF_FFFF, "R6 still clamped");
    rd(A_CST, 32'hFFFF_FFF7, "R6 R7 released");
    rd(A_CMD, 32'h0, "R6 cmd cleared");

    // R8 removal on unpowered partition 10
    wr(A_CMD, 32'h400);
    rd(A_CMD, 32'h0, "R8 cmd dropped");
    idle(8);
    rd(A_CST, 32'hFFFF_FFF7, "R8 clamp kept");

    // R9 crossed pair 5/7, only 5 powered
    wr(A_TOG, 32'h105);
    idle(18);
    rd(A_PWR, 32'h68, "R9 power");
    wr(A_CMD, 32'h20);
    rd(A_CMD, 32'h0, "R9 bit5 targets 7");
    idle(6);
    rd(A_CST, 32'hFFFF_FFF7, "R9 bit5 no effect");
    wr(A_CMD, 32'h80);
    rd(A_CMD, 32'h80, "R9 bit7 pending");
    idle(6);
    rd(A_CST, 32'hFFFF_FFD7, "R9 bit7 releases 5");

    // R11 command while pending ignored
    wr(A_TOG, 32'h108);
    idle(18);
    wr(A_TOG, 32'h109);
    idle(18);
    rd(A_PWR, 32'h368, "R11 power");
    wr(A_CMD, 32'h100);
    wr(A_CMD, 32'h200);
    rd(A_CMD, 32'h100, "R11 second dropped");
    idle(6);
    rd(A_CST, 32'hFFFF_FED7, "R11 clamp");

    // R10 power-off re-clamps
    wr(A_TOG, 32'h103);
    idle(18);
    rd(A_PWR, 32'h360, "R10 power off");
    rd(A_CST, 32'hFFFF_FEDF, "R10 reclamped");

    // R12 writes to status registers ignored
    wr(A_PWR, 32'hFFFF_FFFF);
    wr(A_CST, 32'h0);
    rd(A_PWR, 32'h360, "R12 power ro");
    rd(A_CST, 32'hFFFF_FEDF, "R12 clamp ro");

    idle(3);
    checks++;
    if (expQ.size() != 0) begin
      fails++;
      $display("FAIL R12: missing reads actual %0d expected 0", expQ.size());
    end
    summary();
  end

endmodule